// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock. The division is set by two fields. A 2-bit power-of-two selector picks an intermediate ratio of `2 << div`. A 6-bit even-ratio selector then divides that intermediate rate by `2 * (brg + 1)`. The overall ratio therefore spans 20 to 2048 main-clock cycles per serial-clock period.

A shift engine uses the serial clock together with two single-cycle strobes in the main clock domain. One strobe marks the serial clock leaving its idle level. The other marks it returning to idle. Both strobes are registered and change in the same cycle as the serial clock itself.

The settings are taken in when the block is enabled. While it stays enabled, the block ignores any change to them. The settings are computed from a target frequency elsewhere.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, `sclk` takes the value of `cpol` after that edge, and both strobes are low.
- R2: While `enable` is low at a clock edge, `sclk` takes the present `cpol` after that edge, no strobe is produced, and the internal count is cleared.
- R3: Let H = (2 << div_sel) * (brg_eff + 1) main-clock cycles. The edge that first samples `enable` high is edge 0, and it leaves `sclk` at idle. `sclk` then toggles at edge H and at every H edges after that.
- R4: A `brg_sel` value below 4 acts as 4, so `brg_eff = max(brg_sel, 4)`.
- R5: `lead_stb` is high for exactly the one cycle in which `sclk` has just left the idle level. `trail_stb` is high for exactly the one cycle in which `sclk` has just returned to it. Every transition made while the block runs carries one of the two strobes.
- R6: `lead_stb` and `trail_stb` are never high together, and they alternate, starting with `lead_stb`.
- R7: `cpol`, `div_sel` and `brg_sel` are captured at edge 0. Changes to them while `enable` stays high do not alter the period, the idle level, or the strobes.
- R8: Dropping `enable` returns `sclk` to idle at the next edge with no strobe, even when a toggle was due on that same edge. A later re-enable restarts with a full first half period.
- R9: With `cpol` = 1, the idle level is high, and `lead_stb` marks a falling transition of `sclk`.
- R10: The extreme settings give full-period ratios of 20 (div 0, brg 4) and 2048 (div 3, brg 63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the prescaler; its first high edge captures the settings |
| cpol | input | 1 | Idle level of the serial clock |
| div_sel | input | 2 | Power-of-two stage selector, ratio 2 << div_sel |
| brg_sel | input | 6 | Even-ratio stage selector, ratio 2*(brg_sel+1), floor 4 |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe: sclk has just left idle |
| trail_stb | output | 1 | One-cycle strobe: sclk has just returned to idle |

## Verification
Two functions can land on the same edge. A terminal-count toggle can coincide with `enable` falling. A toggle can also coincide with a change of the settings. The bench drops `enable` so that it is first sampled low on the exact edge where a trailing toggle was due. It judges that edge by requiring an idle `sclk` and a silent `trail_stb`. In a separate run, the bench changes all three settings so that the change is first seen on the first toggle edge. The remaining waveform must still match the period and polarity captured at enable.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int PRE_DIV_W   = 2;
    localparam int PRE_BRG_W   = 6;
    localparam int PRE_BRG_MIN = 4;
    // half period (2<<div)*(brg+1) peaks at 2^(2^DIV_W) * 2^BRG_W
    localparam int PRE_CNT_W   = (1 << PRE_DIV_W) + PRE_BRG_W;

    typedef struct packed {
        logic                 pol;
        logic [PRE_DIV_W-1:0] div;
        logic [PRE_BRG_W-1:0] brg;
    } presc_cfg_t;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_IDLE   = 2'd1,
        PH_ACTIVE = 2'd2
    } presc_phase_t;

    function automatic logic [PRE_BRG_W-1:0] brg_floor(input logic [PRE_BRG_W-1:0] b);
        if (b < PRE_BRG_W'(PRE_BRG_MIN))
            return PRE_BRG_W'(PRE_BRG_MIN);
        return b;
    endfunction

    function automatic presc_cfg_t cfg_sanitize(input logic pol,
                                                input logic [PRE_DIV_W-1:0] div,
                                                input logic [PRE_BRG_W-1:0] brg);
        presc_cfg_t c;
        c.pol = pol;
        c.div = div;
        c.brg = brg_floor(brg);
        return c;
    endfunction

    // half period minus one, in main-clock cycles
    function automatic logic [PRE_CNT_W-1:0] half_minus_one(input presc_cfg_t c);
        logic [PRE_CNT_W:0] p;
        p = (PRE_CNT_W+1)'(c.brg) + (PRE_CNT_W+1)'(1);
        p = p << (int'(c.div) + 1);
        return PRE_CNT_W'(p - (PRE_CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/spi_presc_cfg.sv
module spi_presc_cfg
    import spi_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  presc_cfg_t cfg_live,
    output presc_cfg_t cfg_q
);

    // holds the sanitized settings seen at the enabling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_live;
        end
    end

endmodule

// File: rtl/spi_presc_timer.sv
module spi_presc_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic             running,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign tick    = enable && running && at_zero;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload;
        end else if (running) begin
            if (at_zero)
                cnt_q <= reload;
            else
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_presc_edge.sv
module spi_presc_edge
    import spi_presc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cpol_live,
    input  logic pol_held,
    input  logic tick,
    output logic start,
    output logic running,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);

    presc_phase_t phase_q;

    assign start   = enable && (phase_q == PH_OFF);
    assign running = (phase_q != PH_OFF);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase_q   <= PH_OFF;
            sclk      <= cpol_live;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
            unique case (phase_q)
                PH_OFF: begin
                    phase_q <= PH_IDLE;
                    sclk    <= cpol_live;
                end
                PH_IDLE: begin
                    if (tick) begin
                        phase_q  <= PH_ACTIVE;
                        sclk     <= ~pol_held;
                        lead_stb <= 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (tick) begin
                        phase_q   <= PH_IDLE;
                        sclk      <= pol_held;
                        trail_stb <= 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_OFF;
                    sclk    <= cpol_live;
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_presc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 cpol,
    input  logic [PRE_DIV_W-1:0] div_sel,
    input  logic [PRE_BRG_W-1:0] brg_sel,
    output logic                 sclk,
    output logic                 lead_stb,
    output logic                 trail_stb
);

    localparam int CNT_W = PRE_CNT_W;

    presc_cfg_t       cfg_live;
    presc_cfg_t       cfg_held;
    logic             start;
    logic             running;
    logic             tick;
    logic [CNT_W-1:0] reload;

    assign cfg_live = cfg_sanitize(cpol, div_sel, brg_sel);
    // the first reload comes from the live settings, later ones from the held copy
    assign reload   = start ? half_minus_one(cfg_live) : half_minus_one(cfg_held);

    spi_presc_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .capture  (start),
        .cfg_live (cfg_live),
        .cfg_q    (cfg_held)
    );

    spi_presc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .start   (start),
        .running (running),
        .reload  (reload),
        .tick    (tick)
    );

    spi_presc_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cpol_live (cpol),
        .pol_held  (cfg_held.pol),
        .tick      (tick),
        .start     (start),
        .running   (running),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cpol,
    input logic sclk,
    input logic lead,
    input logic trail
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= 2'd0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sclk == $past(cpol)) && !lead && !trail);

    // R2
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) && !$past(en) |-> (sclk == $past(cpol)) && !lead && !trail);

    // R5
    a_r5_lead_moves: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) && lead |-> sclk != $past(sclk));

    a_r5_trail_moves: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) && trail |-> sclk != $past(sclk));

    a_r5_toggle_strobed: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) && $past(en) && $past(en, 2) && (sclk != $past(sclk)) |-> lead || trail);

    // R6
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail));

endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (enable),
    .cpol  (cpol),
    .sclk  (sclk),
    .lead  (lead_stb),
    .trail (trail_stb)
);

// File: tb/spi_sclk_prescaler_test.sv
module spi_sclk_prescaler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       cpol = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] brg_sel = 6'd4;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spi_sclk_prescaler uut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cpol      (cpol),
        .div_sel   (div_sel),
        .brg_sel   (brg_sel),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    // {cpol, div, brg}
    localparam logic [8:0] VEC [0:7] = '{
        {1'b0, 2'd0, 6'd4},    // R10 smallest ratio
        {1'b1, 2'd0, 6'd4},    // R9
        {1'b0, 2'd1, 6'd7},
        {1'b1, 2'd2, 6'd10},   // R9
        {1'b0, 2'd3, 6'd63},   // R10 largest ratio
        {1'b0, 2'd0, 6'd0},    // R4 floor
        {1'b1, 2'd1, 6'd3},    // R4 floor
        {1'b0, 2'd2, 6'd5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_len(input logic [1:0] d, input logic [5:0] b);
        int be;
        be = (b < 4) ? 4 : int'(b);
        return (2 << d) * (be + 1);
    endfunction

    // Runs one enabled window and compares every cycle with the R3/R5/R6 waveform.
    // change_at >= 0 scrambles the settings after that cycle (R7).
    task automatic run_case(input logic p, input logic [1:0] d, input logic [5:0] b,
                            input int change_at, input string req);
        int h;
        int bad;
        int first_act;
        int first_exp;
        h = half_len(d, b);
        bad = 0;
        first_act = 0;
        first_exp = 0;
        @(negedge clk);
        cpol = p; div_sel = d; brg_sel = b; enable = 1'b1;
        for (int k = 0; k <= 4 * h + 2; k++) begin
            int t;
            bit on;
            logic es, el, et;
            @(posedge clk);
            @(negedge clk);
            t  = k / h;
            on = (k != 0) && (k % h == 0);
            es = p ^ logic'(t & 1);
            el = on && (t % 2 == 1);
            et = on && (t % 2 == 0);
            if (sclk !== es || lead_stb !== el || trail_stb !== et) begin
                if (bad == 0) begin
                    first_act = {sclk, lead_stb, trail_stb};
                    first_exp = {es, el, et};
                end
                bad++;
            end
            if (k == change_at) begin
                cpol = ~p; div_sel = ~d; brg_sel = ~b;
            end
        end
        check(bad == 0, req, first_act, first_exp);
        enable = 1'b0; cpol = p; div_sel = d; brg_sel = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R1: reset drives idle from cpol
        cpol = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sclk === 1'b1 && !lead_stb && !trail_stb, "R1 reset idle high",
              {sclk, lead_stb, trail_stb}, 3'b100);
        cpol = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(sclk === 1'b0, "R1 reset idle low", sclk, 0);
        rst = 1'b0;

        // R2: disabled, sclk follows cpol, no strobes under changing settings
        begin
            int stray;
            stray = 0;
            for (int i = 0; i < 30; i++) begin
                cpol = i[2]; brg_sel = 6'(i); div_sel = 2'(i);
                @(posedge clk);
                @(negedge clk);
                if (sclk !== cpol || lead_stb || trail_stb) stray++;
            end
            check(stray == 0, "R2 disabled follows cpol", stray, 0);
        end

        // R3 R5 R6 R9 R10 R4: table of settings
        for (int v = 0; v < 8; v++) begin
            run_case(VEC[v][8], VEC[v][7:6], VEC[v][5:0], -1, $sformatf("R3 vector %0d", v));
        end

        // R7: settings change lands on first toggle edge, and mid-half
        run_case(1'b0, 2'd0, 6'd4, 9, "R7 change on toggle edge");
        run_case(1'b1, 2'd1, 6'd5, 5, "R7 change mid half");

        // R8: disable on the edge where a trailing toggle was due (H=10, edge 20)
        @(negedge clk);
        cpol = 1'b0; div_sel = 2'd0; brg_sel = 6'd4; enable = 1'b1;
        for (int k = 0; k <= 19; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(sclk === 1'b1, "R8 active before drop", sclk, 1);
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(sclk === 1'b0 && !lead_stb && !trail_stb, "R8 drop on toggle edge",
              {sclk, lead_stb, trail_stb}, 3'b000);
        run_case(1'b0, 2'd0, 6'd4, -1, "R8 restart full half");

        // R8: disable while active, mid half
        @(negedge clk);
        cpol = 1'b1; div_sel = 2'd1; brg_sel = 6'd4; enable = 1'b1;
        for (int k = 0; k <= 25; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(sclk === 1'b1 && !lead_stb && !trail_stb, "R8 drop mid half",
              {sclk, lead_stb, trail_stb}, 3'b100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule